// File: doc/BRIEF.md
# Perturb-and-Observe Power Tracker

This block steers a solar source towards its maximum power point by fixed-step hill climbing. A prescaler produces a sample strobe at a slow update rate, 10 Hz by default. On each strobe the block latches a voltage sample and a current value and multiplies them at full width into a power value. It then compares that power with the power from the previous sample and moves a desired-current register one fixed step up or down. The desired current is turned into a scheduled switching frequency through a linear map: the current shifted left by a gain exponent, plus an offset. That frequency is presented with a one-cycle valid strobe.

The current value comes from one of two places. In sensed mode it is the current input. In voltage-only mode the current input is ignored and the current is estimated from the frequency the block last scheduled, through the inverse of the same map. When the power reads exactly zero, the sign of the comparison is not used. Instead a one-bit toggle alternates the direction of the step, so the register dithers rather than sinking to its floor. The desired current is always held between a programmable floor and a programmable ceiling.

The controller is a four-state machine:
- S_IDLE waits for the strobe. On the strobe it latches the inputs and moves to S_MULT.
- S_MULT registers the product and moves to S_DECIDE.
- S_DECIDE applies the step and the clamp, stores the power and flips the dither bit, then moves to S_PUBLISH.
- S_PUBLISH registers the new frequency and raises the valid strobe, then returns to S_IDLE.

Top module: `pno_tracker`

## Requirements
- R1: While reset is held, and after it is released, the desired current equals the floor input, the frequency output equals the map of the floor, the valid strobe is 0, the stored previous power is 0 and the dither bit is 0.
- R2: When the new power is non-zero and strictly greater than the stored previous power, the desired current rises by STEP, before clamping.
- R3: When the new power is non-zero and less than or equal to the stored previous power, the desired current falls by STEP, before clamping (it saturates at 0 before clamping).
- R4: When the new power is exactly 0, the step goes up if the dither bit is 0 and down if it is 1. The dither bit inverts on every decision, whatever the power.
- R5: After each decision the desired current is clamped to the range [floor, ceiling], using the floor and ceiling inputs as they stand during that decision.
- R6: The frequency output equals (desired current << GSH) + OFFSET and is updated once per decision.
- R7: The valid strobe is high for exactly one clock per decision, and successive strobes are DIV clocks apart.
- R8: With the mode input at 1, the current used in the product is the inverse map of the frequency output, ((f − OFFSET) >> GSH, or 0 if f < OFFSET), and the current input has no effect. With the mode input at 0, the current input is used.
- R9: The product is kept at full width, VW+IW bits, so that two powers differing by 1 LSB still steer the step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| volt_only | input | 1 | 1: estimate current from the scheduled frequency; 0: use the current input |
| volt_in | input | VW | Unsigned voltage sample |
| cur_in | input | IW | Unsigned current sample (sensed mode only) |
| i_floor | input | IW | Lower clamp for the desired current; loaded at reset |
| i_ceil | input | IW | Upper clamp for the desired current |
| freq_out | output | IW+GSH+1 | Scheduled switching frequency |
| freq_vld | output | 1 | One-cycle strobe marking a new frequency |
| i_set | output | IW | Present desired current |

## Verification
The bench builds the tracker with DIV = 8, STEP = 2, GSH = 2 and OFFSET = 1000. The short prescaler makes a decision happen every eight clocks, so dozens of hill-climbing steps, clamps at both ends and dither sequences fit in a short run. A step of 2 makes the floor clamp visible: from one LSB above the floor, a plain subtraction would land below the floor. The offset and gain make the inverse map used in voltage-only mode differ from the identity. The 12-bit data widths let full-scale products and 1-LSB power differences be exercised together.

// File: rtl/pno_pkg.sv
package pno_pkg;
    typedef enum logic [1:0] {
        S_IDLE    = 2'd0,
        S_MULT    = 2'd1,
        S_DECIDE  = 2'd2,
        S_PUBLISH = 2'd3
    } pno_state_e;
endpackage

// File: rtl/pno_ticker.sv
module pno_ticker #(
    parameter int DIV = 10_000_000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else begin
            tick <= (cnt == LAST);
            cnt  <= (cnt == LAST) ? '0 : cnt + 1'b1;
        end
    end
endmodule

// File: rtl/pno_freq_map.sv
module pno_freq_map #(
    parameter int IW     = 12,
    parameter int GSH    = 2,
    parameter int OFFSET = 1000,
    localparam int FW    = IW + GSH + 1
) (
    input  logic [IW-1:0] i_val,
    output logic [FW-1:0] f_val,
    input  logic [FW-1:0] f_in,
    output logic [IW-1:0] i_est
);
    localparam logic [FW-1:0] OFF_W = FW'(OFFSET);
    localparam logic [FW-1:0] I_TOP = FW'((1 << IW) - 1);

    logic [FW-1:0] diff;
    logic [FW-1:0] shifted;

    always_comb begin
        f_val   = (FW'(i_val) << GSH) + OFF_W;
        diff    = (f_in >= OFF_W) ? (f_in - OFF_W) : '0;
        shifted = diff >> GSH;
        i_est   = (shifted > I_TOP) ? I_TOP[IW-1:0] : shifted[IW-1:0];
    end
endmodule

// File: rtl/pno_step.sv
module pno_step #(
    parameter int IW   = 12,
    parameter int STEP = 1
) (
    input  logic [IW-1:0] i_cur,
    input  logic          go_up,
    input  logic [IW-1:0] i_lo,
    input  logic [IW-1:0] i_hi,
    output logic [IW-1:0] i_next
);
    localparam logic [IW:0] STEP_W = (IW+1)'(STEP);
    localparam logic [IW:0] TOP_W  = (IW+1)'((1 << IW) - 1);

    logic [IW:0] raw;

    always_comb begin
        if (go_up)
            raw = ({1'b0, i_cur} + STEP_W > TOP_W) ? TOP_W : {1'b0, i_cur} + STEP_W;
        else
            raw = ({1'b0, i_cur} < STEP_W) ? '0 : {1'b0, i_cur} - STEP_W;
        if (raw > {1'b0, i_hi})
            i_next = i_hi;
        else if (raw < {1'b0, i_lo})
            i_next = i_lo;
        else
            i_next = raw[IW-1:0];
    end
endmodule

// File: rtl/pno_tracker.sv
module pno_tracker #(
    parameter int VW     = 12,
    parameter int IW     = 12,
    parameter int STEP   = 1,
    parameter int GSH    = 2,
    parameter int OFFSET = 1000,
    parameter int DIV    = 10_000_000,
    localparam int FW    = IW + GSH + 1,
    localparam int PW    = VW + IW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          volt_only,
    input  logic [VW-1:0] volt_in,
    input  logic [IW-1:0] cur_in,
    input  logic [IW-1:0] i_floor,
    input  logic [IW-1:0] i_ceil,
    output logic [FW-1:0] freq_out,
    output logic          freq_vld,
    output logic [IW-1:0] i_set
);
    import pno_pkg::*;

    localparam logic [IW:0] STEP_W = (IW+1)'(STEP);

    pno_state_e    state, state_nx;
    logic          tick;
    logic [VW-1:0] v_q;
    logic [IW-1:0] c_q;
    logic [PW-1:0] p_now, p_prev;
    logic signed [PW:0] err;
    logic          dither;
    logic          go_up;
    logic [IW-1:0] i_next, i_est;
    logic [FW-1:0] f_new;

    pno_ticker #(.DIV(DIV)) u_tick (.clk(clk), .rst_n(rst_n), .tick(tick));

    pno_freq_map #(.IW(IW), .GSH(GSH), .OFFSET(OFFSET)) u_map (
        .i_val(i_set), .f_val(f_new), .f_in(freq_out), .i_est(i_est)
    );

    pno_step #(.IW(IW), .STEP(STEP)) u_step (
        .i_cur(i_set), .go_up(go_up), .i_lo(i_floor), .i_hi(i_ceil), .i_next(i_next)
    );

    // signed error; only its sign matters
    always_comb begin
        err   = $signed({1'b0, p_now}) - $signed({1'b0, p_prev});
        go_up = (p_now == '0) ? ~dither : (err > 0);
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:    if (tick) state_nx = S_MULT;
            S_MULT:    state_nx = S_DECIDE;
            S_DECIDE:  state_nx = S_PUBLISH;
            S_PUBLISH: state_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_q      <= '0;
            c_q      <= '0;
            p_now    <= '0;
            p_prev   <= '0;
            dither   <= 1'b0;
            i_set    <= i_floor;
            freq_out <= (FW'(i_floor) << GSH) + FW'(OFFSET);
            freq_vld <= 1'b0;
        end else begin
            freq_vld <= 1'b0;
            unique case (state)
                S_IDLE: if (tick) begin
                    v_q <= volt_in;
                    c_q <= volt_only ? i_est : cur_in;
                end
                S_MULT:   p_now <= PW'(v_q) * PW'(c_q);
                S_DECIDE: begin
                    i_set  <= i_next;
                    p_prev <= p_now;
                    dither <= ~dither;
                end
                S_PUBLISH: begin
                    freq_out <= f_new;
                    freq_vld <= 1'b1;
                end
            endcase
        end
    end

    // R7: strobe lasts one cycle
    p_vld_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        freq_vld |=> !freq_vld);

    // R6: frequency matches desired current whenever announced
    p_freq_map_r6: assert property (@(posedge clk) disable iff (!rst_n)
        freq_vld |-> freq_out == (FW'(i_set) << GSH) + FW'(OFFSET));

    // R4: dither bit inverts on every decision
    p_dither_flip_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_PUBLISH) |-> dither != $past(dither));

    // R5: after a decision the current lies within the clamp range
    p_clamp_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_PUBLISH && $stable(i_floor) && $stable(i_ceil) && i_floor <= i_ceil)
        |-> (i_set >= i_floor && i_set <= i_ceil));

    // R2/R3: from an in-range value the move is at most one step
    p_step_size_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_PUBLISH && $stable(i_floor) && $stable(i_ceil)
         && $past(i_set) >= i_floor && $past(i_set) <= i_ceil)
        |-> ({1'b0, i_set} <= {1'b0, $past(i_set)} + STEP_W
             && {1'b0, i_set} + STEP_W >= {1'b0, $past(i_set)}));

    // R5: desired current holds between decisions
    p_hold_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE) |=> $stable(i_set));
endmodule

// File: tb/sim_pno_tracker.sv
module sim_pno_tracker;
    localparam int VW = 12, IW = 12, STEP = 2, GSH = 2, OFFSET = 1000, DIV = 8;
    localparam int FW = IW + GSH + 1;
    localparam int NV = 16;
    // {mode, voltage, current}
    localparam logic [24:0] VEC [NV] = '{
        {1'b0, 12'd100,  12'd50},
        {1'b0, 12'd100,  12'd60},
        {1'b0, 12'd100,  12'd40},
        {1'b0, 12'd100,  12'd40},
        {1'b0, 12'd100,  12'd40},
        {1'b0, 12'd0,    12'd40},
        {1'b0, 12'd0,    12'd40},
        {1'b0, 12'd0,    12'd40},
        {1'b0, 12'd1,    12'd4000},
        {1'b0, 12'd1,    12'd4001},
        {1'b0, 12'd4095, 12'd4095},
        {1'b1, 12'd200,  12'd999},
        {1'b1, 12'd300,  12'd5},
        {1'b1, 12'd300,  12'd3000},
        {1'b1, 12'd100,  12'd7},
        {1'b1, 12'd0,    12'd7}
    };

    logic clk = 0, rst_n = 0, volt_only = 0;
    logic [VW-1:0] volt_in = 0;
    logic [IW-1:0] cur_in = 0, i_floor = 10, i_ceil = 30;
    logic [FW-1:0] freq_out;
    logic freq_vld;
    logic [IW-1:0] i_set;

    int n_chk = 0, n_bad = 0;
    int m_i, m_prev, m_dith;
    bit done = 0;

    always #2.5 clk = ~clk;

    pno_tracker #(.VW(VW), .IW(IW), .STEP(STEP), .GSH(GSH), .OFFSET(OFFSET), .DIV(DIV)) u0 (
        .clk(clk), .rst_n(rst_n), .volt_only(volt_only), .volt_in(volt_in), .cur_in(cur_in),
        .i_floor(i_floor), .i_ceil(i_ceil), .freq_out(freq_out), .freq_vld(freq_vld), .i_set(i_set)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int fmap(input int i);
        return (i << GSH) + OFFSET;
    endfunction

    task automatic wait_vld();
        @(negedge clk);
        while (!freq_vld) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 0;
        repeat (3) @(negedge clk);
        chk("R1 i_set in reset", int'(i_set), int'(i_floor));
        rst_n = 1;
        m_i = int'(i_floor); m_prev = 0; m_dith = 0;
        @(negedge clk);
        chk("R1 i_set after reset", int'(i_set), m_i);
        chk("R1 freq after reset", int'(freq_out), fmap(m_i));
        chk("R1 vld after reset", int'(freq_vld), 0);
    endtask

    // apply one sample, model the decision, compare
    task automatic run_vec(input bit md, input int v, input int c, input string req);
        int cur, p, raw;
        bit up;
        volt_only = md; volt_in = VW'(v); cur_in = IW'(c);
        cur = md ? m_i : c;   // R8: estimated current equals last scheduled current
        p = v * cur;
        up = (p == 0) ? (m_dith == 0) : (p > m_prev);
        m_dith ^= 1;
        m_prev = p;
        raw = up ? ((m_i + STEP > 4095) ? 4095 : m_i + STEP) : ((m_i < STEP) ? 0 : m_i - STEP);
        if (raw > int'(i_ceil)) raw = int'(i_ceil);
        else if (raw < int'(i_floor)) raw = int'(i_floor);
        m_i = raw;
        wait_vld();
        chk(req, int'(i_set), m_i);
        chk("R6 freq map", int'(freq_out), fmap(m_i));
    endtask

    initial begin
        int gap;
        do_reset();
        for (int k = 0; k < NV; k++)
            run_vec(VEC[k][24], int'(VEC[k][23:12]), int'(VEC[k][11:0]),
                    VEC[k][24] ? "R8 volt-only step" : "R2 R3 R4 R9 step");

        // R7: one-cycle strobe, DIV apart
        wait_vld();
        @(negedge clk);
        chk("R7 vld width", int'(freq_vld), 0);
        gap = 1;
        while (!freq_vld) begin @(negedge clk); gap++; end
        chk("R7 vld spacing", gap, DIV);

        // R8: measured current ignored in volt-only mode; resync model
        do_reset();
        run_vec(1'b1, 50, 4095, "R8 ignore sensor A");
        run_vec(1'b1, 50, 0,    "R8 ignore sensor B");

        // R9: 1-LSB power difference steers upward
        do_reset();
        run_vec(1'b0, 4095, 4094, "R9 base");
        run_vec(1'b0, 4095, 4094, "R3 equal power falls");
        run_vec(1'b0, 1, 16760930 / 4095, "R3 lower power");
        run_vec(1'b0, 3, 1, "R3 lower again");
        run_vec(1'b0, 4, 1, "R9 one LSB higher rises");

        // R5: ceiling clamp
        i_ceil = 13;
        for (int k = 1; k <= 4; k++) run_vec(1'b0, 100, 10 * k, "R5 ceiling clamp");
        chk("R5 at ceiling", int'(i_set), 13);
        // R5: floor clamp with a step larger than the gap
        i_ceil = 30; i_floor = 12;
        for (int k = 0; k < 3; k++) run_vec(1'b0, 100, 100 - 10 * k, "R5 floor clamp");
        chk("R5 at floor", int'(i_set), 12);

        // R4: zero-power dither alternates
        for (int k = 0; k < 4; k++) run_vec(1'b0, 0, 0, "R4 dither");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule